// File: doc/BRIEF.md
# HDLC NRZI Bit Transmitter

This block is the serial end of a packet transmitter for an audio frequency-shift keyed link. It advances only on a sample tick. Each tick marks one audio sample, and one line bit lasts a fixed number of ticks. After a start pulse it sends a run of flag bytes as a preamble. It then pulls packet bytes from a ready/valid byte port, one byte at each byte boundary, and adds a closing flag after every byte marked as the last of its packet. Bits go out least significant first. A zero is stuffed after five consecutive ones of ordinary data. Every bit is NRZI coded onto a mark/space select line.

A byte can be marked as raw on the input port. Raw bytes, and every flag the block generates itself, go out unstuffed, and they reset the run of ones. A burst ends when the packet limit has been reached or when no byte is offered at a byte boundary. A start pulse during a burst is ignored.

Top module: `hdlc_nrzi_tx`

## Requirements
- R1: After reset and whenever the block is idle, `busy`, `tone_en`, `tone_mark` and `in_ready` are all 0.
- R2: Each line bit is held for TICKS_PER_BIT (default 8) ticks. Clock cycles with `tick` low freeze the bit timing and the tone.
- R3: After a start pulse, PREAMBLE_FLAGS (default 23) flag bytes of value 0x7E are sent before any input byte is accepted.
- R4: Every byte is sent least significant bit first.
- R5: For ordinary bytes (`in_is_flag`=0), a 0 is inserted after five consecutive 1 bits. The inserted 0 does not consume a data bit.
- R6: Bytes offered with `in_is_flag`=1, and all generated flags, are never stuffed. Each of their bits clears the run of ones.
- R7: NRZI coding: a 0 bit toggles `tone_mark` and a 1 bit keeps it. `tone_mark`=1 selects mark and 0 selects space. `tone_mark` is 0 at the start of a burst.
- R8: After a byte accepted with `in_last`=1, one 0x7E flag is sent. The next packet's first byte follows it directly.
- R9: At most MAX_PACKETS (default 3) packets, each closed by its flag, are sent per burst. Further queued bytes are not accepted.
- R10: If no byte is valid at a byte boundary where one may be taken, the burst ends. `busy` and `tone_en` fall TICKS_PER_BIT ticks after the last bit (or the last stuffed zero) began.
- R11: A start pulse while `busy` is 1 has no effect on the bit stream.
- R12: `in_ready` is 1 only in a tick cycle at a byte boundary after the preamble, with no closing flag pending and the packet limit not reached. A byte is taken when `in_valid` and `in_ready` are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Sample tick strobe |
| start | input | 1 | Burst start request |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Offered byte |
| in_is_flag | input | 1 | Byte is raw framing, send unstuffed |
| in_last | input | 1 | Byte ends its packet |
| in_ready | output | 1 | Byte taken this cycle if valid |
| busy | output | 1 | Burst in progress |
| tone_en | output | 1 | Tone generator enable, high once the first bit is driven |
| tone_mark | output | 1 | 1 = mark tone, 0 = space tone |

## Verification
A stuffed zero and a byte boundary can fall due in the same bit slot. This happens when an ordinary byte ending in five ones is followed by a fetch, by the closing flag, or by the end of the burst. The bench provokes it with all-ones payloads at the end of packets and at the end of a truncated packet. Its reference model inserts the zero before the fetch, so the whole NRZI tone sequence is compared bit by bit. The bench also checks that the stop happens only one bit period after the stuffed zero.

// File: rtl/hdlc_nrzi_tx.sv
module hdlc_nrzi_tx #(
  parameter int TICKS_PER_BIT  = 8,
  parameter int PREAMBLE_FLAGS = 23,
  parameter int MAX_PACKETS    = 3,
  parameter int STUFF_LIMIT    = 5,
  parameter logic [7:0] FLAG_BYTE = 8'h7E
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       start,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_is_flag,
  input  logic       in_last,
  output logic       in_ready,
  output logic       busy,
  output logic       tone_en,
  output logic       tone_mark
);
  localparam int TW = $clog2(TICKS_PER_BIT);
  localparam int PW = $clog2(PREAMBLE_FLAGS + 1);
  localparam int KW = $clog2(MAX_PACKETS + 1);
  localparam int OW = $clog2(STUFF_LIMIT + 1);

  logic          busy_q, ten_q, tone_q, raw_q, close_pend;
  logic [TW-1:0] tcnt;
  logic [3:0]    bits_left;
  logic [7:0]    shreg;
  logic [OW-1:0] ones;
  logic [PW-1:0] pre_cnt;
  logic [KW-1:0] pkt_cnt;

  logic bit_slot, do_stuff, need_byte, internal_flag, take, stop_now, out_bit, cur_raw;
  logic [7:0] cur_byte;

  assign bit_slot      = busy_q && tick && (tcnt == '0);
  assign do_stuff      = bit_slot && (ones == OW'(STUFF_LIMIT));
  assign need_byte     = bit_slot && !do_stuff && (bits_left == 4'd0);
  assign internal_flag = (pre_cnt != '0) || close_pend;
  assign in_ready      = need_byte && !internal_flag && (pkt_cnt != KW'(MAX_PACKETS));
  assign take          = in_ready && in_valid;
  assign stop_now      = need_byte && !internal_flag && !take;

  assign cur_byte = !need_byte ? shreg : (internal_flag ? FLAG_BYTE : in_data);
  assign cur_raw  = !need_byte ? raw_q : (internal_flag ? 1'b1 : in_is_flag);
  assign out_bit  = do_stuff ? 1'b0 : cur_byte[0];

  assign busy      = busy_q;
  assign tone_en   = ten_q;
  assign tone_mark = tone_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0; ten_q <= 1'b0; tone_q <= 1'b0; raw_q <= 1'b0;
      close_pend <= 1'b0; tcnt <= '0; bits_left <= 4'd0; shreg <= 8'd0;
      ones <= '0; pre_cnt <= '0; pkt_cnt <= '0;
    end else if (start && !busy_q) begin
      busy_q <= 1'b1; ten_q <= 1'b0; tone_q <= 1'b0;
      close_pend <= 1'b0; tcnt <= '0; bits_left <= 4'd0;
      ones <= '0; pre_cnt <= PW'(PREAMBLE_FLAGS); pkt_cnt <= '0;
    end else if (busy_q && tick) begin
      if (stop_now) begin
        busy_q <= 1'b0;
        ten_q  <= 1'b0;
        tone_q <= 1'b0;
      end else begin
        tcnt <= (tcnt == TW'(TICKS_PER_BIT - 1)) ? '0 : tcnt + 1'b1;
        if (bit_slot) begin
          ten_q  <= 1'b1;
          tone_q <= out_bit ? tone_q : ~tone_q;
          ones   <= (!out_bit || cur_raw) ? '0 : ones + 1'b1;
          if (!do_stuff) begin
            shreg     <= cur_byte >> 1;
            raw_q     <= cur_raw;
            bits_left <= need_byte ? 4'd7 : bits_left - 4'd1;
          end
          if (need_byte) begin
            if (pre_cnt != '0) pre_cnt <= pre_cnt - 1'b1;
            else if (close_pend) begin
              close_pend <= 1'b0;
              pkt_cnt    <= pkt_cnt + 1'b1;
            end else close_pend <= in_last;
          end
        end
      end
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (!ten_q && !tone_q && !in_ready));
  assert_tone_held_between_slots_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !bit_slot && !start) |=> $stable(tone_q));
  assert_no_data_in_preamble_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (pre_cnt == '0));
  assert_stuff_keeps_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    do_stuff |=> ($stable(bits_left) && $stable(shreg)));
  assert_run_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ones <= OW'(STUFF_LIMIT));
  assert_packet_limit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_cnt == KW'(MAX_PACKETS)) |-> !in_ready);
  assert_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start && !tick) |=> ($stable(pre_cnt) && $stable(tcnt) && busy_q));
endmodule

// File: tb/hdlc_nrzi_tx_tb_top.sv
module hdlc_nrzi_tx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PRE = 23;
  localparam int TPB = 8;
  localparam int NV  = 7;
  // {npk[4], len[4], seed[8], vary, flag_idx[4], trunc, pause, restart}
  localparam logic [23:0] VEC [0:NV-1] = '{
    {4'd1, 4'd4, 8'h11, 1'b1, 4'hF, 3'b000},
    {4'd2, 4'd3, 8'hFF, 1'b0, 4'hF, 3'b000},
    {4'd4, 4'd2, 8'hA5, 1'b1, 4'hF, 3'b000},
    {4'd1, 4'd3, 8'hFF, 1'b0, 4'd1, 3'b000},
    {4'd0, 4'd1, 8'h00, 1'b0, 4'hF, 3'b000},
    {4'd2, 4'd3, 8'hFF, 1'b0, 4'hF, 3'b111},
    {4'd3, 4'd5, 8'h5A, 1'b1, 4'hF, 3'b000}
  };

  logic clk = 0, rst_n = 0, tick = 0, start = 0;
  logic in_ready, busy, tone_en, tone_mark;
  logic [7:0] qd [0:63];
  logic qf [0:63];
  logic ql [0:63];
  int qn = 0, base = 0, acc = 0;
  int total = 0, bad = 0;
  logic exp_tone [0:2047];
  int exp_n, exp_used;
  bit done = 0;

  wire        in_valid   = (acc - base) < qn;
  wire [7:0]  in_data    = in_valid ? qd[(acc - base) % 64] : 8'h00;
  wire        in_is_flag = in_valid ? qf[(acc - base) % 64] : 1'b0;
  wire        in_last    = in_valid ? ql[(acc - base) % 64] : 1'b0;

  hdlc_nrzi_tx dut_i (.clk(clk), .rst_n(rst_n), .tick(tick), .start(start),
    .in_valid(in_valid), .in_data(in_data), .in_is_flag(in_is_flag), .in_last(in_last),
    .in_ready(in_ready), .busy(busy), .tone_en(tone_en), .tone_mark(tone_mark));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (in_valid && in_ready) acc <= acc + 1;

  task automatic chk(input bit ok, input string what, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, expv);
    end
  endtask

  task automatic wait_ticks(input int n);
    int c = 0;
    while (c < n) begin
      @(posedge clk);
      if (tick) c++;
    end
  endtask

  task automatic build_model();
    int ones = 0, idx = 0, cnt = 0;
    bit pend = 0, t = 0;
    logic bits [0:2047];
    exp_n = 0;
    for (int b = 0; b < PRE + 64 + 8; b++) begin
      logic [7:0] by; bit fl;
      if (b < PRE) begin by = 8'h7E; fl = 1; end
      else if (pend) begin by = 8'h7E; fl = 1; pend = 0; cnt++; end
      else if (cnt == 3 || idx >= qn) break;
      else begin by = qd[idx]; fl = qf[idx]; pend = ql[idx]; idx++; end
      for (int j = 0; j < 8; j++) begin
        if (ones == 5) begin bits[exp_n] = 0; exp_n++; ones = 0; end
        bits[exp_n] = by[j]; exp_n++;
        ones = (!by[j] || fl) ? 0 : ones + 1;
      end
    end
    if (ones == 5) begin bits[exp_n] = 0; exp_n++; end
    exp_used = idx;
    for (int k = 0; k < exp_n; k++) begin
      if (!bits[k]) t = ~t;
      exp_tone[k] = t;
    end
  endtask

  task automatic run_vector(input logic [23:0] v);
    int npk = int'(v[23:20]), len = int'(v[19:16]), fi = int'(v[6:3]);
    logic [7:0] seed = v[15:8];
    int miss = 0, n = 0, first_miss = -1;
    logic held;
    for (int p = 0; p < npk; p++)
      for (int i = 0; i < len; i++) begin
        qd[n] = v[7] ? (seed ^ 8'((p * 7 + i) * 53)) : seed;
        qf[n] = 0;
        if (p == 0 && i == fi) begin qd[n] = 8'hFF; qf[n] = 1; end
        ql[n] = (i == len - 1) && !(v[2] && p == npk - 1);
        n++;
      end
    base = acc; qn = n;
    build_model();
    start = 1;
    @(posedge clk);
    @(negedge clk) start = 0;
    chk(busy === 1'b1, "R1 busy after start", busy, 1);
    for (int k = 0; k < exp_n; k++) begin
      wait_ticks(k == 0 ? 1 : TPB);
      @(negedge clk);
      if (tone_mark !== exp_tone[k] || tone_en !== 1'b1) begin
        miss++;
        if (first_miss < 0) first_miss = k;
      end
      if (k == PRE * 8 - 1) chk(acc - base == 0, "R3 R12 no byte taken during preamble", acc - base, 0);
      if (k == PRE * 8 && npk > 0) chk(acc - base == 1, "R3 R12 first byte taken after preamble", acc - base, 1);
      if (v[1] && k == 190) begin
        held = tone_mark;
        tick = 0;
        repeat (20) @(negedge clk);
        chk(tone_mark === held && busy === 1'b1, "R2 tone frozen without tick", tone_mark, held);
        tick = 1;
      end
      if (v[0] && k == 30) begin
        start = 1;
        fork begin @(negedge clk); start = 0; end join_none
      end
    end
    chk(miss == 0, "R4 R5 R6 R7 R8 R11 tone stream mismatches (first at bit)", first_miss, -1);
    wait_ticks(TPB);
    @(negedge clk);
    chk(busy === 1'b0 && tone_en === 1'b0, "R10 burst ended one bit after last", busy, 0);
    chk(acc - base == exp_used, "R9 R12 bytes accepted in burst", acc - base, exp_used);
    qn = 0; base = acc;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy === 0 && tone_en === 0 && tone_mark === 0 && in_ready === 0, "R1 reset state", busy, 0);
    rst_n = 1;
    tick = 1;
    @(negedge clk);
    chk(busy === 0 && in_ready === 0, "R1 idle without start", busy, 0);
    for (int vi = 0; vi < NV; vi++) run_vector(VEC[vi]);
    tick = 0;
    start = 1;
    @(negedge clk) start = 0;
    repeat (10) @(negedge clk);
    chk(busy === 1 && tone_en === 0 && tone_mark === 0, "R2 no bit without ticks", tone_en, 0);
    chk(in_ready === 0, "R12 no ready without tick", in_ready, 0);
    rst_n = 0;
    @(negedge clk);
    chk(busy === 0 && tone_en === 0, "R1 reset ends burst", busy, 0);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin @(posedge clk); cyc++; end
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule